// File: doc/BRIEF.md
# Two-Lane Serial Parity Predictor and Corrector

This block is the back end of a serial encoder for quasi-cyclic codes with a dual-diagonal parity part. An upstream stage holds the base matrix and two circular shifters. Each cycle it delivers up to two shifted Z-bit sub-blocks. Each sub-block comes with the block-row it belongs to and a flag that marks it as the final contribution to that row. The block XOR-accumulates each row's lambda. When a row's final contribution arrives, the block turns that lambda into a running parity prediction at once.

The rows form two chains. Rows 0 to MB/2-1 form the top chain, which is extended downward. Rows MB-1 down to MB/2 form the bottom chain, which is extended upward. The producer must complete the rows of each chain in chain order: row 0, 1, 2 and so on at the top, and row MB-1, MB-2 and so on at the bottom. Once every row has a prediction, the block derives the first parity sub-block from the two middle predictions. It then streams out all MB corrected parity sub-blocks, one per cycle. After the last one it is ready for the next codeword.

Both edges are valid/ready streams. A beat is taken on the input only when `in_valid` and `in_ready` are both high. `in_ready` is high exactly while the block is collecting. On the output, a parity beat moves only when `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered beat is held unchanged. The error flag is a plain level.

Top module: `parity_predict_serial`

## Requirements
- R1: After reset, `in_ready`=1, `out_valid`=0 and `err_repeat`=0. `in_ready` and `out_valid` are never high together: input is refused for the whole output phase.
- R2: In a taken beat, every enabled lane XORs its data into the lambda of its row. When both lanes name the same row, both contributions are added.
- R3: Top chain: when row r (r < MB/2) completes, its prediction becomes its final lambda XOR the prediction of row r-1. Row 0 uses its lambda alone. Once stored, a prediction does not change until the codeword has been drained.
- R4: Bottom chain: when row r (r >= MB/2) completes, its prediction becomes its final lambda XOR the prediction of row r+1. Row MB-1 uses its lambda alone.
- R5: Two rows that are neighbours in the same chain may complete in one beat. The later row in the chain then uses the prediction that the earlier row produces in that same beat.
- R6: Let H = MB/2. Output beat 0 is P0, the XOR of the predictions of rows H-1 and H.
- R7: Output beat j, for 1 <= j <= H, is the prediction of row j-1 XOR P0. For H < j < MB it is the prediction of row j XOR P0. Output starts in the cycle after the beat that completes the last row.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_last` keep their values.
- R9: `out_last` is high on beat MB-1 only. The cycle after that beat is taken, the block is collecting again, with all lambdas and predictions cleared.
- R10: A last flag for a row that already has a prediction sets `err_repeat` and does not alter that row's prediction. The flag stays set until the codeword's final output beat is taken.
- R11: A lane whose enable bit is 0 has no effect, whatever its row, data and last flag carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block accepts input (collect phase) |
| in_lane_en | input | 2 | Per-lane enable, bit l for lane l |
| in_row | input | 2*RW | Block-row index per lane, lane l at bits [l*RW +: RW] |
| in_data | input | 2*Z | Shifted sub-block per lane, lane l at bits [l*Z +: Z] |
| in_lane_last | input | 2 | Per-lane final-contribution flag for its row |
| out_valid | output | 1 | Corrected parity beat offered |
| out_ready | input | 1 | Consumer accepts the parity beat |
| out_data | output | Z | Corrected parity sub-block |
| out_last | output | 1 | Final parity beat of the codeword |
| err_repeat | output | 1 | Sticky flag: a row was completed twice |

## Verification
The function most likely to collide with another is row completion. In one beat the same row can receive an added contribution and also complete. Two neighbouring rows of one chain can also complete in a single beat, so that one prediction feeds the next through logic without passing a register. The bench provokes both cases. It puts both lanes on one row with the last flag on only one of them. It completes rows 0 and 1 together, and rows 5 and 4 together. It then judges every drained parity beat against predictions that it builds itself from per-row lambdas it has summed. A repeated completion is also sent in the same beat as fresh data for another row. This shows that the error path and normal accumulation do not disturb each other.

// File: rtl/apu_pkg.sv
`timescale 1ns/1ps
package apu_pkg;
  localparam int LANES = 2;
  typedef enum logic {ST_COLLECT = 1'b0, ST_DRAIN = 1'b1} apu_state_e;
endpackage

// File: rtl/apu_row_slice.sv
`timescale 1ns/1ps
module apu_row_slice
  import apu_pkg::*;
#(
  parameter int Z      = 24,
  parameter int RW     = 4,
  parameter int ROW_ID = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                clr,
  input  logic [LANES-1:0]    lane_en,
  input  logic [LANES*RW-1:0] lane_row,
  input  logic [LANES*Z-1:0]  lane_data,
  input  logic [LANES-1:0]    lane_last,
  input  logic [Z-1:0]        chain_in,
  output logic [Z-1:0]        chain_out,
  output logic [Z-1:0]        pred_q,
  output logic                done_q,
  output logic                fin,
  output logic                dup
);
  localparam logic [RW-1:0] MY_ROW = RW'(ROW_ID);

  logic [Z-1:0] lam_q, add_w, lam_next;
  logic         last_hit;

  always_comb begin
    add_w    = '0;
    last_hit = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_en[l] && lane_row[l*RW +: RW] == MY_ROW) begin
        add_w = add_w ^ lane_data[l*Z +: Z];
        if (lane_last[l]) last_hit = 1'b1;
      end
    end
  end

  assign lam_next  = lam_q ^ add_w;
  assign fin       = take && last_hit && !done_q;
  assign dup       = take && last_hit && done_q;
  assign chain_out = fin ? (lam_next ^ chain_in) : pred_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lam_q  <= '0;
      pred_q <= '0;
      done_q <= 1'b0;
    end else if (clr) begin
      lam_q  <= '0;
      pred_q <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      lam_q <= lam_next;
      if (fin) begin
        pred_q <= chain_out;
        done_q <= 1'b1;
      end
    end
  end

  a_r3_pred_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr) |=> (done_q && $stable(pred_q)));
endmodule

// File: rtl/apu_ctrl.sv
`timescale 1ns/1ps
module apu_ctrl
  import apu_pkg::*;
#(
  parameter int MB = 12,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          all_done_nxt,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          out_last,
  output logic [RW-1:0] beat_idx,
  output logic          clr
);
  localparam logic [RW-1:0] LAST_IDX = RW'(MB - 1);

  apu_state_e st_q;
  logic [RW-1:0] idx_q;
  logic fire;

  assign in_ready  = (st_q == ST_COLLECT);
  assign out_valid = (st_q == ST_DRAIN);
  assign out_last  = out_valid && (idx_q == LAST_IDX);
  assign beat_idx  = idx_q;
  assign fire      = out_valid && out_ready;
  assign clr       = fire && out_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_COLLECT;
      idx_q <= '0;
    end else begin
      case (st_q)
        ST_COLLECT: begin
          idx_q <= '0;
          if (all_done_nxt) st_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (fire) begin
            if (out_last) begin
              st_q  <= ST_COLLECT;
              idx_q <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_COLLECT;
      endcase
    end
  end

  a_r1_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  a_r9_back_to_collect: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));
  a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (idx_q <= LAST_IDX));
endmodule

// File: rtl/apu_parity_sel.sv
`timescale 1ns/1ps
module apu_parity_sel #(
  parameter int Z  = 24,
  parameter int MB = 12,
  parameter int RW = 4
) (
  input  logic [MB*Z-1:0] preds,
  input  logic [RW-1:0]   idx,
  output logic [Z-1:0]    data
);
  localparam int H = MB / 2;

  logic [Z-1:0] p0;
  assign p0 = preds[(H-1)*Z +: Z] ^ preds[H*Z +: Z];

  always_comb begin
    int k;
    k = int'(idx);
    if (k == 0)          data = p0;
    else if (k <= H)     data = preds[(k-1)*Z +: Z] ^ p0;
    else if (k < MB)     data = preds[k*Z +: Z] ^ p0;
    else                 data = '0;
  end
endmodule

// File: rtl/parity_predict_serial.sv
`timescale 1ns/1ps
module parity_predict_serial
  import apu_pkg::*;
#(
  parameter int Z  = 24,
  parameter int MB = 12,
  parameter int RW = (MB > 1) ? $clog2(MB) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES-1:0]    in_lane_en,
  input  logic [LANES*RW-1:0] in_row,
  input  logic [LANES*Z-1:0]  in_data,
  input  logic [LANES-1:0]    in_lane_last,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [Z-1:0]        out_data,
  output logic                out_last,
  output logic                err_repeat
);
  localparam int H = MB / 2;

  logic          take, clr;
  logic [RW-1:0] beat_idx;
  logic [MB-1:0] fin, dup, done;
  logic [Z-1:0]  chain_out [MB];
  logic [Z-1:0]  chain_in  [MB];
  logic [MB*Z-1:0] preds;
  logic          err_q;

  assign take = in_valid && in_ready;

  generate
    for (genvar r = 0; r < MB; r++) begin : g_row
      if (r == 0 || r == MB - 1) begin : g_head
        assign chain_in[r] = '0;
      end else if (r < H) begin : g_top
        assign chain_in[r] = chain_out[r-1];
      end else begin : g_bot
        assign chain_in[r] = chain_out[r+1];
      end

      apu_row_slice #(.Z(Z), .RW(RW), .ROW_ID(r)) u_row (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .clr       (clr),
        .lane_en   (in_lane_en),
        .lane_row  (in_row),
        .lane_data (in_data),
        .lane_last (in_lane_last),
        .chain_in  (chain_in[r]),
        .chain_out (chain_out[r]),
        .pred_q    (preds[r*Z +: Z]),
        .done_q    (done[r]),
        .fin       (fin[r]),
        .dup       (dup[r])
      );
    end
  endgenerate

  apu_ctrl #(.MB(MB), .RW(RW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .all_done_nxt (&(done | fin)),
    .out_ready    (out_ready),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_last     (out_last),
    .beat_idx     (beat_idx),
    .clr          (clr)
  );

  apu_parity_sel #(.Z(Z), .MB(MB), .RW(RW)) u_sel (
    .preds (preds),
    .idx   (beat_idx),
    .data  (out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     err_q <= 1'b0;
    else if (clr)   err_q <= 1'b0;
    else if (|dup)  err_q <= 1'b1;
  end
  assign err_repeat = err_q;

  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_repeat && !clr) |=> err_repeat);
  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_repeat) |-> $past(in_valid && in_ready));
endmodule

// File: tb/parity_predict_serial_tb_top.sv
`timescale 1ns/1ps
module parity_predict_serial_tb_top;
  localparam int Z  = 8;
  localparam int MB = 6;
  localparam int RW = 3;
  localparam int H  = MB / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [1:0] in_lane_en = '0, in_lane_last = '0;
  logic [2*RW-1:0] in_row = '0;
  logic [2*Z-1:0]  in_data = '0;
  logic in_ready, out_valid, out_last, err_repeat;
  logic [Z-1:0] out_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [Z-1:0] lam_m [MB];
  logic         done_m [MB];

  always #10 clk = ~clk;

  parity_predict_serial #(.Z(Z), .MB(MB), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_lane_en(in_lane_en), .in_row(in_row), .in_data(in_data),
    .in_lane_last(in_lane_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .err_repeat(err_repeat)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic model_clear();
    for (int r = 0; r < MB; r++) begin lam_m[r] = '0; done_m[r] = 1'b0; end
  endtask

  // one beat; lane l: enable, row, data, last
  task automatic send(input logic e0, input int r0, input logic [Z-1:0] d0, input logic l0,
                      input logic e1, input int r1, input logic [Z-1:0] d1, input logic l1);
    chk(in_ready == 1'b1, "R1 in_ready while collecting", in_ready, 1);
    in_valid = 1'b1;
    in_lane_en = {e1, e0};
    in_row = {RW'(r1), RW'(r0)};
    in_data = {d1, d0};
    in_lane_last = {l1, l0};
    if (e0 && !done_m[r0]) lam_m[r0] ^= d0;
    if (e1 && !done_m[r1]) lam_m[r1] ^= d1;
    if (e0 && l0) done_m[r0] = 1'b1;
    if (e1 && l1) done_m[r1] = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    in_lane_en = '0;
    in_lane_last = '0;
  endtask

  task automatic drain(input int stall);
    logic [Z-1:0] tp [MB];
    logic [Z-1:0] ex [MB];
    logic [Z-1:0] p0, acc;
    acc = '0;
    for (int r = 0; r < H; r++) begin acc ^= lam_m[r]; tp[r] = acc; end      // R3
    acc = '0;
    for (int r = MB-1; r >= H; r--) begin acc ^= lam_m[r]; tp[r] = acc; end  // R4
    p0 = tp[H-1] ^ tp[H];                                                      // R6
    ex[0] = p0;
    for (int j = 1; j < MB; j++) ex[j] = (j <= H) ? (tp[j-1] ^ p0) : (tp[j] ^ p0); // R7
    for (int j = 0; j < MB; j++) begin
      for (int s = 0; s < stall; s++) begin
        out_ready = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(out_valid == 1'b1 && out_data == ex[j] && out_last == (j == MB-1),
            "R8 held beat under stall", out_data, ex[j]);
      end
      out_ready = 1'b1;
      chk(out_valid == 1'b1, "R7 out_valid during drain", out_valid, 1);
      chk(out_data == ex[j], (j == 0) ? "R6 P0 beat" : "R7 corrected parity", out_data, ex[j]);
      chk(out_last == (j == MB-1), "R9 out_last position", out_last, j == MB-1);
      chk(in_ready == 1'b0, "R1 input refused in drain", in_ready, 0);
      @(posedge clk); @(negedge clk);
    end
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R9 back to collect", {in_ready, out_valid}, 2);
    chk(err_repeat == 1'b0, "R10 flag cleared after drain", err_repeat, 0);
    model_clear();
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    chk(err_repeat == 1'b0, "R1 reset err_repeat", err_repeat, 0);
  endtask

  task automatic t_columns();  // R3 R4 R7: top/bottom toward middle over two columns
    send(1,0,8'h11,0, 1,5,8'h82,0);
    send(1,1,8'h23,0, 1,4,8'h47,0);
    send(1,2,8'h5a,0, 1,3,8'h3c,0);
    send(1,0,8'h0f,1, 1,5,8'hf0,1);
    send(1,1,8'h99,1, 1,4,8'h66,1);
    chk(out_valid == 1'b0, "R7 no output before all rows", out_valid, 0);
    send(1,2,8'ha5,1, 1,3,8'h5a,1);
    drain(0);
  endtask

  task automatic t_same_cycle();  // R2 R5 R11
    send(1,2,8'h13,0, 1,2,8'h31,0);           // R2 both lanes on row 2
    send(1,3,8'h44,0, 0,0,8'hff,1);           // R11 disabled lane with last on row 0
    chk(out_valid == 1'b0, "R11 disabled last completes nothing", out_valid, 0);
    send(1,0,8'h07,1, 1,1,8'h70,1);           // R5 top neighbours together
    send(1,5,8'hc3,1, 1,4,8'h3c,1);           // R5 bottom neighbours together
    send(1,2,8'h81,0, 1,2,8'h18,1);           // R2 same row, last on one lane
    send(1,3,8'h29,1, 0,2,8'hee,1);           // R11 disabled lane on done row
    chk(err_repeat == 1'b0, "R11 disabled lane raises no error", err_repeat, 0);
    drain(0);
  endtask

  task automatic t_repeat();  // R10
    send(1,0,8'h5d,1, 1,5,8'h2b,1);
    chk(err_repeat == 1'b0, "R10 no error on first completion", err_repeat, 0);
    send(1,0,8'hff,1, 1,1,8'h61,0);           // repeat on row 0 with fresh data on row 1
    chk(err_repeat == 1'b1, "R10 error on repeated completion", err_repeat, 1);
    send(1,1,8'h0c,1, 1,4,8'h77,1);
    chk(err_repeat == 1'b1, "R10 error sticky", err_repeat, 1);
    send(1,2,8'h19,1, 1,3,8'h91,1);
    drain(1);
  endtask

  task automatic t_backpressure();  // R8 R1
    send(1,0,8'hde,1, 1,5,8'had,1);
    send(1,1,8'hbe,1, 1,4,8'hef,1);
    send(1,2,8'h12,1, 1,3,8'h34,1);
    drain(3);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_columns();
    t_same_cycle();
    t_repeat();
    t_backpressure();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule